// File: doc/BRIEF.md
# ADC Offset and Gain Calibration Engine

This block sits between the decimation stage of a 24-bit sigma-delta converter and its host interface. Each raw two's-complement result goes through an offset and gain correction. The block then codes the result as straight binary (unipolar) or offset binary (bipolar), clamps it to the 24-bit code range, and presents it as conversion data.

Calibration is started by writing a calibration code into the mode field. The engine then treats the next raw result as a calibration measurement and does not output it as data. An offset calibration stores the measured value into the offset coefficient. A gain calibration divides the ideal full-scale code by the offset-corrected measurement, using a sequential divider, and stores the quotient into the gain coefficient. When either calibration completes, the ready flag drops and the engine falls back to standby. Both coefficients can always be read at the ports.

The offset coefficient is referenced to midscale, so 0x800000 means no correction. The gain coefficient is referenced to 0x400000, which means unity. With these defaults, the ideal full-scale input code of 0x600000 gives 0xC00000 in unipolar coding and 0xE00000 in bipolar coding. Neither value reaches the end of the code range.

Top module: `adc_cal_engine`

## Requirements
- R1: After reset the mode is standby (code 1), the offset coefficient is 0x800000, the gain coefficient is 0x400000, `rdy_n` is low, `dout` is 0 and `dout_vld` is low.
- R2: The mode codes are: 0 continuous conversion, 1 standby, 4 internal offset, 5 internal gain, 6 system offset, 7 system gain. A write of code 2 or 3 leaves the mode unchanged. Any mode write while `rdy_n` is high leaves the mode unchanged.
- R3: In continuous conversion mode, each `raw_vld` cycle produces a one-cycle `dout_vld` two clock edges later, and `bipolar` is sampled together with that sample. In any other mode a raw sample produces no `dout_vld` and leaves `dout` unchanged.
- R4: In bipolar coding, `dout` = floor(d × gain / 2^22) + 0x800000, where d = raw − (offset − 0x800000), with raw taken as a signed 24-bit value.
- R5: In unipolar coding, `dout` = floor(d × gain / 2^21), with the same d as in R4.
- R6: A corrected value below 0 is output as 0x000000. A corrected value above 0xFFFFFF is output as 0xFFFFFF. Values never wrap.
- R7: `rdy_n` goes high on the clock edge that accepts a calibration code. It stays high until the calibration result has been stored.
- R8: During an offset calibration (code 4 or 6), the next raw sample is stored as offset = raw + 0x800000 modulo 2^24. On that same edge `rdy_n` goes low and the mode becomes standby.
- R9: `zero_tie` is high exactly while the mode is internal offset calibration (code 4). It asks for both modulator inputs to be tied to the negative input.
- R10: During a gain calibration (code 5 or 7), the next raw sample gives d as in R4, using the stored offset. The stored gain is floor(0x600000 × 2^22 / d). The gain is 0xFFFFFF if d ≤ 0 or if the quotient exceeds 0xFFFFFF. The result is stored at most 50 edges after the sample, and then `rdy_n` goes low and the mode becomes standby. Samples that arrive while the divider runs are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_we | input | 1 | Mode field write strobe |
| mode_wdata | input | 3 | Mode code to write |
| bipolar | input | 1 | 1 selects offset-binary output coding, 0 selects unipolar |
| raw_vld | input | 1 | Raw sample strobe |
| raw_data | input | 24 | Raw two's-complement modulator result |
| dout | output | 24 | Corrected conversion data |
| dout_vld | output | 1 | One-cycle strobe for new `dout` |
| rdy_n | output | 1 | High while a calibration is in progress |
| zero_tie | output | 1 | Request to short both modulator inputs to the negative input |
| offset_q | output | 24 | Offset coefficient readback |
| gain_q | output | 24 | Gain coefficient readback |
| mode_q | output | 3 | Current mode code |

## Verification
A mode write is visible on `mode_q` and `rdy_n` after the edge that takes it. An offset coefficient appears on the edge that takes the calibration sample. Corrected data appears two edges after its sample. A gain result arrives up to fifty edges after its sample. The bench drives inputs and samples outputs on falling edges, so each check reads the value present after the exact edge counted for that result. The vector table streams samples back to back and checks vector i two falling edges after it was driven. The gain calibration completion is polled, and a bound is placed on the latency.

// File: rtl/adc_cal_pkg.sv
package adc_cal_pkg;

  typedef enum logic [2:0] {
    MD_CONV  = 3'd0,
    MD_IDLE  = 3'd1,
    MD_IOFF  = 3'd4,
    MD_IGAIN = 3'd5,
    MD_SOFF  = 3'd6,
    MD_SGAIN = 3'd7
  } cal_mode_e;

  function automatic logic mode_legal(input logic [2:0] code);
    return code[2:1] != 2'b01;
  endfunction

  function automatic logic mode_is_cal(input logic [2:0] code);
    return code[2];
  endfunction

  function automatic logic mode_is_off(input logic [2:0] code);
    return code[2] && !code[0];
  endfunction

  function automatic logic mode_is_gain(input logic [2:0] code);
    return code[2] && code[0];
  endfunction

endpackage

// File: rtl/cal_corrector.sv
module cal_corrector #(
  parameter int DW = 24
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_vld,
  input  logic                 bip,
  input  logic [DW-1:0]        raw,
  input  logic [DW-1:0]        offset,
  input  logic [DW-1:0]        gain,
  output logic signed [DW+1:0] diff,
  output logic [DW-1:0]        dout,
  output logic                 dout_vld
);
  localparam int PW = 2*DW + 3;
  localparam logic [DW-1:0]        MID    = DW'(1) << (DW-1);
  localparam logic [DW-1:0]        MAXC   = '1;
  localparam logic signed [PW-1:0] MID_S  = $signed(PW'(MID));
  localparam logic signed [PW-1:0] MAX_S  = $signed(PW'(MAXC));

  logic signed [DW+1:0] off_adj;
  logic signed [PW-1:0] dx, gx, prod_c;

  assign off_adj = $signed({2'b00, offset}) - $signed({2'b00, MID});
  assign diff    = $signed({{2{raw[DW-1]}}, raw}) - off_adj;
  assign dx      = PW'(diff);
  assign gx      = $signed({{(PW-DW){1'b0}}, gain});
  assign prod_c  = dx * gx;

  logic                 s1_vld, s1_bip;
  logic signed [PW-1:0] s1_prod;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld  <= 1'b0;
      s1_bip  <= 1'b0;
      s1_prod <= '0;
    end else begin
      s1_vld <= in_vld;
      if (in_vld) begin
        s1_bip  <= bip;
        s1_prod <= prod_c;
      end
    end
  end

  logic signed [PW-1:0] scaled;
  assign scaled = s1_bip ? ((s1_prod >>> (DW-2)) + MID_S) : (s1_prod >>> (DW-3));

  always_ff @(posedge clk) begin
    if (rst) begin
      dout     <= '0;
      dout_vld <= 1'b0;
    end else begin
      dout_vld <= s1_vld;
      if (s1_vld) begin
        if (scaled < 0)          dout <= '0;
        else if (scaled > MAX_S) dout <= MAXC;
        else                     dout <= scaled[DW-1:0];
      end
    end
  end

  // R3
  out_vld_chk: assert property (@(posedge clk) disable iff (rst)
    dout_vld |-> $past(s1_vld));
  // R3
  stage_vld_chk: assert property (@(posedge clk) disable iff (rst)
    s1_vld |-> $past(in_vld));
endmodule

// File: rtl/cal_divider.sv
module cal_divider #(
  parameter int NW  = 48,
  parameter int DVW = 26
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [NW-1:0]  dividend,
  input  logic [DVW-1:0] divisor,
  output logic           busy,
  output logic           done,
  output logic [NW-1:0]  quot
);
  localparam int RW = DVW + 1;
  localparam int CW = $clog2(NW + 1);

  logic [NW-1:0]  dvd;
  logic [DVW-1:0] dvs;
  logic [RW-1:0]  rem;
  logic [CW-1:0]  cnt;
  logic [RW-1:0]  rem_sh;
  logic           take;

  assign rem_sh = {rem[RW-2:0], dvd[NW-1]};
  assign take   = rem_sh >= {1'b0, dvs};

  always_ff @(posedge clk) begin
    if (rst) begin
      dvd  <= '0;
      dvs  <= '0;
      rem  <= '0;
      cnt  <= '0;
      quot <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        dvd  <= dividend;
        dvs  <= divisor;
        rem  <= '0;
        quot <= '0;
        cnt  <= CW'(NW);
        busy <= 1'b1;
      end else if (busy) begin
        dvd  <= dvd << 1;
        rem  <= take ? (rem_sh - {1'b0, dvs}) : rem_sh;
        quot <= {quot[NW-2:0], take};
        cnt  <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  // R10
  div_start_chk: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy);
  // R10
  div_done_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(busy));
endmodule

// File: rtl/cal_ctrl.sv
module cal_ctrl
  import adc_cal_pkg::*;
#(
  parameter int DW = 24
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 mode_we,
  input  logic [2:0]           mode_wdata,
  input  logic                 raw_vld,
  input  logic [DW-1:0]        raw_data,
  input  logic signed [DW+1:0] diff,
  input  logic                 div_done,
  input  logic [2*DW-1:0]      div_quot,
  output logic                 div_start,
  output logic [DW+1:0]        div_divisor,
  output logic                 conv_en,
  output logic [2:0]           mode_q,
  output logic [DW-1:0]        offset_q,
  output logic [DW-1:0]        gain_q,
  output logic                 rdy_n,
  output logic                 zero_tie
);
  localparam logic [DW-1:0] MID   = DW'(1) << (DW-1);
  localparam logic [DW-1:0] UNITY = DW'(1) << (DW-2);
  localparam logic [DW-1:0] MAXC  = '1;

  logic wait_div, take_sample, gain_sat;

  assign take_sample = rdy_n && !wait_div && raw_vld;
  assign gain_sat    = diff <= 0;
  assign div_start   = take_sample && mode_is_gain(mode_q) && !gain_sat;
  assign div_divisor = diff;
  assign conv_en     = mode_q == MD_CONV;
  assign zero_tie    = mode_q == MD_IOFF;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= MD_IDLE;
      offset_q <= MID;
      gain_q   <= UNITY;
      rdy_n    <= 1'b0;
      wait_div <= 1'b0;
    end else begin
      if (!rdy_n) begin
        if (mode_we && mode_legal(mode_wdata)) begin
          mode_q <= mode_wdata;
          if (mode_is_cal(mode_wdata)) rdy_n <= 1'b1;
        end
      end else if (take_sample) begin
        if (mode_is_off(mode_q)) begin
          offset_q <= raw_data ^ MID;
          rdy_n    <= 1'b0;
          mode_q   <= MD_IDLE;
        end else if (gain_sat) begin
          gain_q <= MAXC;
          rdy_n  <= 1'b0;
          mode_q <= MD_IDLE;
        end else begin
          wait_div <= 1'b1;
        end
      end
      if (div_done) begin
        gain_q   <= (|div_quot[2*DW-1:DW]) ? MAXC : div_quot[DW-1:0];
        rdy_n    <= 1'b0;
        mode_q   <= MD_IDLE;
        wait_div <= 1'b0;
      end
    end
  end

  // R7
  rdy_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rdy_n) |-> $past(mode_we) && mode_is_cal(mode_q));
  // R8
  off_done_chk: assert property (@(posedge clk) disable iff (rst)
    (take_sample && mode_is_off(mode_q)) |=> (!rdy_n && mode_q == MD_IDLE));
  // R2
  busy_write_chk: assert property (@(posedge clk) disable iff (rst)
    (rdy_n && mode_we && !raw_vld && !div_done) |=> $stable(mode_q));
  // R8
  off_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(take_sample && mode_is_off(mode_q)) |=> $stable(offset_q));
endmodule

// File: rtl/adc_cal_engine.sv
module adc_cal_engine #(
  parameter int DW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mode_we,
  input  logic [2:0]    mode_wdata,
  input  logic          bipolar,
  input  logic          raw_vld,
  input  logic [DW-1:0] raw_data,
  output logic [DW-1:0] dout,
  output logic          dout_vld,
  output logic          rdy_n,
  output logic          zero_tie,
  output logic [DW-1:0] offset_q,
  output logic [DW-1:0] gain_q,
  output logic [2:0]    mode_q
);
  localparam int QW = 2*DW;
  localparam logic [DW-1:0] FS_CODE = DW'(3) << (DW-3);
  localparam logic [QW-1:0] FS_DVD  = QW'(FS_CODE) << (DW-2);

  logic signed [DW+1:0] diff;
  logic                 conv_en, div_start, div_busy, div_done;
  logic [DW+1:0]        div_divisor;
  logic [QW-1:0]        div_quot;

  cal_corrector #(.DW(DW)) u_corr (
    .clk(clk), .rst(rst),
    .in_vld(raw_vld && conv_en), .bip(bipolar), .raw(raw_data),
    .offset(offset_q), .gain(gain_q), .diff(diff),
    .dout(dout), .dout_vld(dout_vld)
  );

  cal_divider #(.NW(QW), .DVW(DW+2)) u_div (
    .clk(clk), .rst(rst), .start(div_start),
    .dividend(FS_DVD), .divisor(div_divisor),
    .busy(div_busy), .done(div_done), .quot(div_quot)
  );

  cal_ctrl #(.DW(DW)) u_ctrl (
    .clk(clk), .rst(rst), .mode_we(mode_we), .mode_wdata(mode_wdata),
    .raw_vld(raw_vld), .raw_data(raw_data), .diff(diff),
    .div_done(div_done), .div_quot(div_quot), .div_start(div_start),
    .div_divisor(div_divisor), .conv_en(conv_en), .mode_q(mode_q),
    .offset_q(offset_q), .gain_q(gain_q), .rdy_n(rdy_n), .zero_tie(zero_tie)
  );

  // R10
  busy_rdy_chk: assert property (@(posedge clk) disable iff (rst)
    div_busy |-> rdy_n);
  // R3
  no_data_in_cal_chk: assert property (@(posedge clk) disable iff (rst)
    (rdy_n && $past(rdy_n)) |-> !dout_vld);
endmodule

// File: tb/adc_cal_engine_bench.sv
module adc_cal_engine_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode_we = 1'b0;
  logic [2:0]  mode_wdata = '0;
  logic        bipolar = 1'b0;
  logic        raw_vld = 1'b0;
  logic [23:0] raw_data = '0;
  logic [23:0] dout, offset_q, gain_q;
  logic        dout_vld, rdy_n, zero_tie;
  logic [2:0]  mode_q;

  int nchk = 0;
  int nerr = 0;

  always #2.5 clk = ~clk;

  adc_cal_engine u_adc_cal_engine (
    .clk(clk), .rst(rst), .mode_we(mode_we), .mode_wdata(mode_wdata),
    .bipolar(bipolar), .raw_vld(raw_vld), .raw_data(raw_data),
    .dout(dout), .dout_vld(dout_vld), .rdy_n(rdy_n), .zero_tie(zero_tie),
    .offset_q(offset_q), .gain_q(gain_q), .mode_q(mode_q)
  );

  // {bipolar, raw, expected} with default coefficients
  localparam int NV = 11;
  localparam logic [48:0] VEC [NV] = '{
    {1'b1, 24'h000000, 24'h800000},
    {1'b0, 24'h000000, 24'h000000},
    {1'b1, 24'h600000, 24'hE00000},
    {1'b0, 24'h600000, 24'hC00000},
    {1'b0, 24'h100000, 24'h200000},
    {1'b1, 24'hF00000, 24'h700000},
    {1'b0, 24'hF00000, 24'h000000},
    {1'b1, 24'h7FFFFF, 24'hFFFFFF},
    {1'b0, 24'h7FFFFF, 24'hFFFFFE},
    {1'b1, 24'h800000, 24'h000000},
    {1'b1, 24'h123456, 24'h923456}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] model_out(input logic [23:0] raw, input logic [23:0] off,
                                            input logic [23:0] g, input logic bip);
    longint d, p, t;
    d = longint'($signed(raw)) - (longint'(off) - 64'sh800000);
    p = d * longint'(g);
    t = bip ? ((p >>> 22) + 64'sh800000) : (p >>> 21);
    if (t < 0) return 24'h000000;
    if (t > 64'shFFFFFF) return 24'hFFFFFF;
    return t[23:0];
  endfunction

  function automatic logic [23:0] model_gain(input logic [23:0] raw, input logic [23:0] off);
    longint d, q;
    d = longint'($signed(raw)) - (longint'(off) - 64'sh800000);
    if (d <= 0) return 24'hFFFFFF;
    q = (64'sh600000 <<< 22) / d;
    if (q > 64'shFFFFFF) return 24'hFFFFFF;
    return q[23:0];
  endfunction

  task automatic write_mode(input logic [2:0] code);
    @(negedge clk); mode_we = 1'b1; mode_wdata = code;
    @(negedge clk); mode_we = 1'b0;
  endtask

  task automatic send_raw(input logic [23:0] v, input logic bip);
    @(negedge clk); raw_vld = 1'b1; raw_data = v; bipolar = bip;
    @(negedge clk); raw_vld = 1'b0;
  endtask

  task automatic conv_check(input string req, input logic [23:0] v, input logic bip);
    logic [23:0] exp;
    exp = model_out(v, offset_q, gain_q, bip);
    send_raw(v, bip);
    @(negedge clk);
    chk({req, " vld"}, 32'(dout_vld), 32'd1);
    chk(req, 32'(dout), 32'(exp));
  endtask

  task automatic gain_cal(input string req, input logic [2:0] code, input logic [23:0] v);
    logic [23:0] exp;
    int n;
    write_mode(code);
    chk("R7 rdy_n high at start", 32'(rdy_n), 32'd1);
    exp = model_gain(v, offset_q);
    send_raw(v, 1'b0);
    n = 1;
    while (rdy_n && n < 200) begin @(negedge clk); n++; end
    chk({req, " latency bound"}, 32'(n <= 50), 32'd1);
    chk(req, 32'(gain_q), 32'(exp));
    chk("R10 standby after gain cal", 32'(mode_q), 32'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 mode", 32'(mode_q), 32'd1);
    chk("R1 offset", 32'(offset_q), 32'h800000);
    chk("R1 gain", 32'(gain_q), 32'h400000);
    chk("R1 rdy_n", 32'(rdy_n), 32'd0);
    chk("R1 dout", 32'(dout), 32'd0);
    chk("R1 dout_vld", 32'(dout_vld), 32'd0);

    // R3 standby ignores samples
    send_raw(24'h123456, 1'b1);
    @(negedge clk);
    chk("R3 standby no vld", 32'(dout_vld), 32'd0);
    chk("R3 standby dout held", 32'(dout), 32'd0);

    // R2 reserved code ignored
    write_mode(3'd2);
    chk("R2 code 2 ignored", 32'(mode_q), 32'd1);
    write_mode(3'd3);
    chk("R2 code 3 ignored", 32'(mode_q), 32'd1);
    write_mode(3'd0);
    chk("R2 conv mode", 32'(mode_q), 32'd0);

    // R3 R4 R5 R6 streamed table
    for (int i = 0; i < NV + 2; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        chk("R3 stream vld", 32'(dout_vld), 32'd1);
        chk(VEC[i-2][48] ? "R4 table" : "R5 table", 32'(dout), 32'(VEC[i-2][23:0]));
      end
      if (i < NV) begin
        raw_vld = 1'b1; bipolar = VEC[i][48]; raw_data = VEC[i][47:24];
      end else raw_vld = 1'b0;
    end

    // R8 system offset calibration
    write_mode(3'd6);
    chk("R7 rdy_n after offset write", 32'(rdy_n), 32'd1);
    chk("R9 no tie in system offset", 32'(zero_tie), 32'd0);
    send_raw(24'h001000, 1'b1);
    chk("R8 offset stored", 32'(offset_q), 32'h801000);
    chk("R8 rdy_n low", 32'(rdy_n), 32'd0);
    chk("R8 standby", 32'(mode_q), 32'd1);

    // R10 system gain calibration with busy checks
    write_mode(3'd7);
    send_raw(24'h501000, 1'b0);
    chk("R7 rdy_n held during divide", 32'(rdy_n), 32'd1);
    write_mode(3'd0);
    chk("R2 write ignored while busy", 32'(mode_q), 32'd7);
    send_raw(24'h222222, 1'b0);
    @(negedge clk);
    chk("R10 sample ignored while busy", 32'(dout_vld), 32'd0);
    while (rdy_n) @(negedge clk);
    chk("R10 gain value", 32'(gain_q), 32'h4CCCCC);
    chk("R10 standby", 32'(mode_q), 32'd1);

    write_mode(3'd0);
    conv_check("R4 corrected bipolar", 24'h501000, 1'b1);
    chk("R4 literal", 32'(dout), 32'hDFFFFF);

    // R9 R8 internal offset calibration
    write_mode(3'd4);
    chk("R9 tie during internal offset", 32'(zero_tie), 32'd1);
    send_raw(24'hFFF000, 1'b0);
    chk("R8 negative offset", 32'(offset_q), 32'h7FF000);
    chk("R9 tie released", 32'(zero_tie), 32'd0);

    gain_cal("R10 unity gain", 3'd5, 24'h5FF000);
    chk("R10 unity literal", 32'(gain_q), 32'h400000);
    write_mode(3'd0);
    conv_check("R5 unipolar with offset", 24'h100000, 1'b0);

    gain_cal("R10 quotient clamp", 3'd7, 24'h0FF000);
    write_mode(3'd0);
    conv_check("R6 high clamp", 24'h300000, 1'b0);
    chk("R6 literal high", 32'(dout), 32'hFFFFFF);
    conv_check("R6 low clamp", 24'h900000, 1'b1);
    chk("R6 literal low", 32'(dout), 32'h000000);

    gain_cal("R10 gain 1.5", 3'd7, 24'h3FF000);
    chk("R10 literal 1.5", 32'(gain_q), 32'h600000);
    write_mode(3'd0);
    conv_check("R4 scaled bipolar", 24'hC00000, 1'b1);

    gain_cal("R10 nonpositive d", 3'd5, 24'hFFE000);
    chk("R10 literal saturate", 32'(gain_q), 32'hFFFFFF);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule